// File: doc/BRIEF.md
# Paired-Register Compare-and-Swap Operand and Write-Back Unit

This block sits between instruction issue and the memory unit for atomic compare-and-swap operations. From a destination index, a second source index and a 2-bit size code, it reads the compare value and the swap value out of a small register file model. When the operation is twice the base register width, each value comes from an even/odd register pair. Otherwise each value comes from a single register. It rejects encodings that cannot be executed. For a legal operation it presents one registered request to the memory unit.

When the memory unit answers with the old memory contents, the block writes that value back into the destination register or the destination pair. It applies the zero-register rules: a pair that starts at register 0 reads as zero and, as a destination, swallows the whole result. A single word result on a 64-bit base is sign-extended. Other producers in the pipeline can write single registers through a side port. At most one operation is in flight at a time.

Top module: `cas_pair_unit`

## Requirements
- R1: Size code 0 is a 32-bit word, 1 a 64-bit double, 2 a 128-bit quad, and 3 is reserved. Pair mode applies when the operation width is twice XLEN: double on XLEN=32, quad on XLEN=64. A quad on XLEN=32 is reserved.
- R2: A reserved size, or pair mode with an odd destination or odd swap index, raises `illegal` for exactly one cycle, starting the cycle after the issue. No memory request is made and `busy` stays low.
- R3: An accepted legal issue produces `mem_req_valid` for one cycle, starting the cycle after the issue, with `mem_req_size` equal to the issued code. `mem_cmp` is read from the destination index and `mem_swp` from the swap index. Both hold steady until the response.
- R4: In pair mode, bits [XLEN-1:0] of the operand come from the even register and bits [2*XLEN-1:XLEN] from the odd register.
- R5: In pair mode, a source pair starting at register 0 yields an all-zero operand, whatever register 1 holds.
- R6: In single mode, the operand is the register value zero-extended to 2*XLEN bits. For a word on XLEN=64, only its low 32 bits are kept, zero-extended.
- R7: On the response for a pair operation, the even register receives response bits [XLEN-1:0] and the odd register receives bits [2*XLEN-1:XLEN], both on the same clock edge.
- R8: On the response for a pair operation whose destination is register 0, no register changes, including register 1.
- R9: On the response for a single operation, a word on XLEN=64 is written sign-extended from bit 31. Any other single operation writes the low XLEN response bits. Register 0 always reads zero.
- R10: `busy` rises with the request and falls on the edge that takes `mem_rsp_valid`. Issues while busy are ignored. A response while not busy writes nothing.
- R11: The side write port updates one register per edge. Writes to register 0 have no effect, and a write-back to the same register on the same edge wins.
- R12: After reset, `busy`, `mem_req_valid` and `illegal` are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Issue strobe for one operation |
| issue_rd | input | AW | Destination / compare register index |
| issue_rs2 | input | AW | Swap register index |
| issue_size | input | 2 | Size code (0 word, 1 double, 2 quad, 3 reserved) |
| ext_we | input | 1 | Side write enable |
| ext_addr | input | AW | Side write register index |
| ext_data | input | XLEN | Side write data |
| mem_req_valid | output | 1 | One-cycle memory request strobe |
| mem_req_size | output | 2 | Size code of the request |
| mem_cmp | output | 2*XLEN | Compare operand |
| mem_swp | output | 2*XLEN | Swap operand |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | 2*XLEN | Old memory value returned |
| illegal | output | 1 | Reserved-encoding flag, one cycle |
| busy | output | 1 | Operation in flight |

## Verification
The hardest situations to reach are those where the zero-register rules hide a value that is really present. One is a pair read at register 0 while register 1 holds non-zero data. Another is a pair write-back to register 0 that must leave register 1 untouched. The stimulus first fills every register, register 1 included, with non-zero values through the side port. It then issues quad operations at index 0 and checks register 1 afterwards by reading it back as the 64-bit swap operand of a later operation. Random operations bias indices toward even values, so that legal pair traffic and its write-backs keep changing the registers that later operations read.

// File: rtl/cas_pair_pkg.sv
// Shared size codes for the paired-register compare-and-swap unit.
// Assumes: size codes are a 2-bit field decoded by the issue stage.
package cas_pair_pkg;
    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_DBL  = 2'd1,
        SZ_QUAD = 2'd2,
        SZ_RSV  = 2'd3
    } cas_size_e;
endpackage

// File: rtl/cas_pair_decode.sv
// Classifies an issued operation: pair mode, narrow word, reserved encoding.
// Assumes: XLEN is 32 or 64; indices are raw register numbers.
module cas_pair_decode
    import cas_pair_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 5
) (
    input  logic [1:0]    size,
    input  logic [AW-1:0] rd,
    input  logic [AW-1:0] rs2,
    output logic          pair_mode,
    output logic          narrow,
    output logic          reserved
);
    logic size_ok;
    logic odd_pair;

    generate
        if (XLEN == 64) begin : g_base64
            // 64-bit base: quad is the paired width, word is narrowed
            assign pair_mode = (size == SZ_QUAD);
            assign narrow    = (size == SZ_WORD);
            assign size_ok   = (size != SZ_RSV);
        end else begin : g_base32
            // 32-bit base: double is the paired width, quad is unsupported
            assign pair_mode = (size == SZ_DBL);
            assign narrow    = 1'b0;
            assign size_ok   = (size == SZ_WORD) || (size == SZ_DBL);
        end
    endgenerate

    // Either pair base odd makes the encoding reserved
    assign odd_pair = pair_mode && (rd[0] || rs2[0]);
    assign reserved = !size_ok || odd_pair;
endmodule

// File: rtl/cas_pair_regfile.sv
// Register file model: two pair read ports, one pair write port for
// write-back, one single-register side write port. Register 0 reads zero.
// Assumes: write-back lo and hi targets differ when both are enabled.
module cas_pair_regfile #(
    parameter int XLEN = 64,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_addr,
    output logic [XLEN-1:0] ra_lo,
    output logic [XLEN-1:0] ra_hi,
    input  logic [AW-1:0]   rb_addr,
    output logic [XLEN-1:0] rb_lo,
    output logic [XLEN-1:0] rb_hi,
    input  logic            wb_we_lo,
    input  logic            wb_we_hi,
    input  logic [AW-1:0]   wb_addr,
    input  logic [XLEN-1:0] wb_data_lo,
    input  logic [XLEN-1:0] wb_data_hi,
    input  logic            ext_we,
    input  logic [AW-1:0]   ext_addr,
    input  logic [XLEN-1:0] ext_data
);
    localparam int NREG = 1 << AW;

    logic [XLEN-1:0] regs [NREG];
    logic [AW-1:0]   wb_hi_addr;
    logic [AW-1:0]   ra_odd;
    logic [AW-1:0]   rb_odd;

    assign wb_hi_addr = {wb_addr[AW-1:1], 1'b1};
    assign ra_odd     = {ra_addr[AW-1:1], 1'b1};
    assign rb_odd     = {rb_addr[AW-1:1], 1'b1};

    // Storage update: write-back lo, then hi, then side port; reg 0 untouched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 1; i < NREG; i++) begin
                if (wb_we_lo && wb_addr == AW'(i))
                    regs[i] <= wb_data_lo;
                else if (wb_we_hi && wb_hi_addr == AW'(i))
                    regs[i] <= wb_data_hi;
                else if (ext_we && ext_addr == AW'(i))
                    regs[i] <= ext_data;
            end
        end
    end

    // Combinational pair reads: given index and its odd partner
    assign ra_lo = regs[ra_addr];
    assign ra_hi = regs[ra_odd];
    assign rb_lo = regs[rb_addr];
    assign rb_hi = regs[rb_odd];

    // High half of a pair write-back lands in the odd register (R7)
    p_pair_hi_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we_hi |=> regs[$past(wb_hi_addr)] == $past(wb_data_hi));

    // Low half lands in the addressed register when it is not register 0 (R7)
    p_pair_lo_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we_lo && wb_addr != '0) |=> regs[$past(wb_addr)] == $past(wb_data_lo));
endmodule

// File: rtl/cas_pair_operand.sv
// Forms one 2*XLEN operand from a register pair or a single register.
// Assumes: lo is the register at the index, hi the odd partner.
module cas_pair_operand #(
    parameter int XLEN = 64
) (
    input  logic              pair_mode,
    input  logic              narrow,
    input  logic              base_zero,
    input  logic [XLEN-1:0]   lo,
    input  logic [XLEN-1:0]   hi,
    output logic [2*XLEN-1:0] opnd
);
    localparam int OPW = 2 * XLEN;

    logic [XLEN-1:0] single_val;

    // Narrow word keeps only its low 32 bits
    assign single_val = narrow ? XLEN'(lo[31:0]) : lo;

    // Select pair, zero pair, or zero-extended single register
    always_comb begin
        if (pair_mode)
            opnd = base_zero ? '0 : {hi, lo};
        else
            opnd = OPW'(single_val);
    end
endmodule

// File: rtl/cas_pair_wb.sv
// Turns a memory response into register-file write enables and data.
// Assumes: fire is a single-cycle strobe; pair destinations are even.
module cas_pair_wb #(
    parameter int XLEN = 64,
    parameter int AW   = 5
) (
    input  logic              fire,
    input  logic              pair_mode,
    input  logic              narrow,
    input  logic [AW-1:0]     rd,
    input  logic [2*XLEN-1:0] rsp,
    output logic              we_lo,
    output logic              we_hi,
    output logic [AW-1:0]     addr,
    output logic [XLEN-1:0]   data_lo,
    output logic [XLEN-1:0]   data_hi
);
    logic signed [31:0] rsp_word;
    logic               dest_live;

    assign rsp_word  = rsp[31:0];
    assign dest_live = fire && (rd != '0);

    // Enables: a zero destination suppresses the whole result
    assign we_lo = dest_live;
    assign we_hi = dest_live && pair_mode;
    assign addr  = rd;

    // Data: pair halves, or sign-extended word, or full low register width
    always_comb begin
        data_hi = rsp[2*XLEN-1:XLEN];
        if (pair_mode)
            data_lo = rsp[XLEN-1:0];
        else if (narrow)
            data_lo = XLEN'(rsp_word);
        else
            data_lo = rsp[XLEN-1:0];
    end
endmodule

// File: rtl/cas_pair_unit.sv
// Top: reads compare/swap operands for an issued compare-and-swap, issues one
// memory request, and writes the returned old value back to the destination.
// Assumes: one operation in flight; the memory unit answers each request once.
module cas_pair_unit
    import cas_pair_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [AW-1:0]     issue_rd,
    input  logic [AW-1:0]     issue_rs2,
    input  logic [1:0]        issue_size,
    input  logic              ext_we,
    input  logic [AW-1:0]     ext_addr,
    input  logic [XLEN-1:0]   ext_data,
    output logic              mem_req_valid,
    output logic [1:0]        mem_req_size,
    output logic [2*XLEN-1:0] mem_cmp,
    output logic [2*XLEN-1:0] mem_swp,
    input  logic              mem_rsp_valid,
    input  logic [2*XLEN-1:0] mem_rsp_data,
    output logic              illegal,
    output logic              busy
);
    localparam int OPW = 2 * XLEN;

    logic            dec_pair;
    logic            dec_narrow;
    logic            dec_rsv;
    logic            accept;
    logic [XLEN-1:0] ra_lo, ra_hi, rb_lo, rb_hi;
    logic [OPW-1:0]  cmp_next, swp_next;
    logic            pair_q, narrow_q;
    logic [AW-1:0]   rd_q;
    logic            wb_fire;
    logic            wb_we_lo, wb_we_hi;
    logic [AW-1:0]   wb_addr;
    logic [XLEN-1:0] wb_data_lo, wb_data_hi;

    assign accept  = issue_valid && !busy;
    assign wb_fire = busy && mem_rsp_valid;

    cas_pair_decode #(.XLEN(XLEN), .AW(AW)) u_dec (
        .size      (issue_size),
        .rd        (issue_rd),
        .rs2       (issue_rs2),
        .pair_mode (dec_pair),
        .narrow    (dec_narrow),
        .reserved  (dec_rsv)
    );

    cas_pair_regfile #(.XLEN(XLEN), .AW(AW)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .ra_addr    (issue_rd),
        .ra_lo      (ra_lo),
        .ra_hi      (ra_hi),
        .rb_addr    (issue_rs2),
        .rb_lo      (rb_lo),
        .rb_hi      (rb_hi),
        .wb_we_lo   (wb_we_lo),
        .wb_we_hi   (wb_we_hi),
        .wb_addr    (wb_addr),
        .wb_data_lo (wb_data_lo),
        .wb_data_hi (wb_data_hi),
        .ext_we     (ext_we),
        .ext_addr   (ext_addr),
        .ext_data   (ext_data)
    );

    cas_pair_operand #(.XLEN(XLEN)) u_cmp (
        .pair_mode (dec_pair),
        .narrow    (dec_narrow),
        .base_zero (issue_rd == '0),
        .lo        (ra_lo),
        .hi        (ra_hi),
        .opnd      (cmp_next)
    );

    cas_pair_operand #(.XLEN(XLEN)) u_swp (
        .pair_mode (dec_pair),
        .narrow    (dec_narrow),
        .base_zero (issue_rs2 == '0),
        .lo        (rb_lo),
        .hi        (rb_hi),
        .opnd      (swp_next)
    );

    cas_pair_wb #(.XLEN(XLEN), .AW(AW)) u_wb (
        .fire      (wb_fire),
        .pair_mode (pair_q),
        .narrow    (narrow_q),
        .rd        (rd_q),
        .rsp       (mem_rsp_data),
        .we_lo     (wb_we_lo),
        .we_hi     (wb_we_hi),
        .addr      (wb_addr),
        .data_lo   (wb_data_lo),
        .data_hi   (wb_data_hi)
    );

    // Request strobes and the illegal flag, one cycle after the issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req_valid <= 1'b0;
            illegal       <= 1'b0;
        end else begin
            mem_req_valid <= accept && !dec_rsv;
            illegal       <= accept && dec_rsv;
        end
    end

    // Operand capture and in-flight context for the write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cmp      <= '0;
            mem_swp      <= '0;
            mem_req_size <= '0;
            rd_q         <= '0;
            pair_q       <= 1'b0;
            narrow_q     <= 1'b0;
        end else if (accept && !dec_rsv) begin
            mem_cmp      <= cmp_next;
            mem_swp      <= swp_next;
            mem_req_size <= issue_size;
            rd_q         <= issue_rd;
            pair_q       <= dec_pair;
            narrow_q     <= dec_narrow;
        end
    end

    // Busy tracks the single outstanding operation
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (accept && !dec_rsv)
            busy <= 1'b1;
        else if (wb_fire)
            busy <= 1'b0;
    end

    // A request is always accompanied by the busy state (R10)
    p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // A response while busy releases the unit (R10)
    p_rsp_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rsp_valid) |=> !busy);

    // The request strobe lasts a single cycle (R3)
    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // Operands hold while waiting for the response (R3)
    p_hold_opnd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req_valid) |-> ($stable(mem_cmp) && $stable(mem_swp)));

    // A rejected encoding never coexists with a request (R2)
    p_illegal_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req_valid && !busy));

    // A pair request always has an even destination base (R2)
    p_pair_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && pair_q) |-> !rd_q[0]);
endmodule

// File: tb/tb_cas_pair_unit.sv
module tb_cas_pair_unit;
    localparam int XLEN = 64;
    localparam int AW   = 5;
    localparam int OPW  = 2 * XLEN;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            issue_valid;
    logic [AW-1:0]   issue_rd, issue_rs2;
    logic [1:0]      issue_size;
    logic            ext_we;
    logic [AW-1:0]   ext_addr;
    logic [XLEN-1:0] ext_data;
    logic            mem_req_valid;
    logic [1:0]      mem_req_size;
    logic [OPW-1:0]  mem_cmp, mem_swp;
    logic            mem_rsp_valid;
    logic [OPW-1:0]  mem_rsp_data;
    logic            illegal, busy;

    int total = 0;
    int bad   = 0;
    logic [XLEN-1:0] model [32];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cas_pair_unit #(.XLEN(XLEN), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_rd(issue_rd), .issue_rs2(issue_rs2),
        .issue_size(issue_size),
        .ext_we(ext_we), .ext_addr(ext_addr), .ext_data(ext_data),
        .mem_req_valid(mem_req_valid), .mem_req_size(mem_req_size),
        .mem_cmp(mem_cmp), .mem_swp(mem_swp),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .illegal(illegal), .busy(busy)
    );

    task automatic check(input string req, input logic [OPW-1:0] act, input logic [OPW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_rsv(input int rd, input int rs2, input int sz);
        return (sz == 3) || (sz == 2 && ((rd % 2) == 1 || (rs2 % 2) == 1));
    endfunction

    function automatic logic [OPW-1:0] exp_opnd(input int idx, input int sz);
        if (sz == 2) return (idx == 0) ? '0 : {model[idx | 1], model[idx]};
        if (sz == 0) return OPW'(model[idx][31:0]);
        return OPW'(model[idx]);
    endfunction

    task automatic model_wb(input int rd, input int sz, input logic [OPW-1:0] d);
        if (rd == 0) return;
        if (sz == 2) begin
            model[rd]     = d[63:0];
            model[rd + 1] = d[127:64];
        end else if (sz == 0) begin
            model[rd] = {{32{d[31]}}, d[31:0]};
        end else begin
            model[rd] = d[63:0];
        end
    endtask

    task automatic ext_write(input int r, input logic [XLEN-1:0] v);
        ext_we = 1'b1; ext_addr = AW'(r); ext_data = v;
        @(posedge clk); @(negedge clk);
        ext_we = 1'b0;
        if (r != 0) model[r] = v;
    endtask

    // Issue one operation, check the request or the flag, then respond
    task automatic run_op(input int rd, input int rs2, input int sz,
                          input logic [OPW-1:0] rsp, input string tag);
        logic rsv;
        rsv = exp_rsv(rd, rs2, sz);
        issue_valid = 1'b1; issue_rd = AW'(rd); issue_rs2 = AW'(rs2); issue_size = 2'(sz);
        @(posedge clk); @(negedge clk);
        issue_valid = 1'b0;
        check({tag, " R2 illegal"}, OPW'(illegal), OPW'(rsv));
        check({tag, " R2 req"}, OPW'(mem_req_valid), OPW'(!rsv));
        if (!rsv) begin
            check({tag, " R3 size"}, OPW'(mem_req_size), OPW'(sz));
            check({tag, " R4 cmp"}, mem_cmp, exp_opnd(rd, sz));
            check({tag, " R4 swp"}, mem_swp, exp_opnd(rs2, sz));
            mem_rsp_valid = 1'b1; mem_rsp_data = rsp;
            @(posedge clk); @(negedge clk);
            mem_rsp_valid = 1'b0;
            model_wb(rd, sz, rsp);
        end
        check({tag, " R10 busy"}, OPW'(busy), '0);
    endtask

    // Read a register through the normal interface as a 64-bit swap operand
    task automatic peek(input int r, input logic [XLEN-1:0] exp, input string tag);
        issue_valid = 1'b1; issue_rd = '0; issue_rs2 = AW'(r); issue_size = 2'd1;
        @(posedge clk); @(negedge clk);
        issue_valid = 1'b0;
        check(tag, mem_swp, OPW'(exp));
        mem_rsp_valid = 1'b1; mem_rsp_data = {$urandom, $urandom, $urandom, $urandom};
        @(posedge clk); @(negedge clk);
        mem_rsp_valid = 1'b0;
    endtask

    function automatic logic [OPW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 32; i++) model[i] = '0;
        rst_n = 1'b0; issue_valid = 1'b0; issue_rd = '0; issue_rs2 = '0; issue_size = '0;
        ext_we = 1'b0; ext_addr = '0; ext_data = '0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        check("R12 busy", OPW'(busy), '0);
        check("R12 req", OPW'(mem_req_valid), '0);
        check("R12 illegal", OPW'(illegal), '0);
        peek(7, '0, "R12 reg7 zero");
        peek(1, '0, "R12 reg1 zero");

        for (int i = 1; i < 32; i++) ext_write(i, {$urandom | 32'h1, $urandom});
        // R11 side write to register 0 is dropped
        ext_write(0, 64'hDEAD_BEEF_0000_0001);
        peek(0, '0, "R11 x0 ignores side write");
        peek(13, model[13], "R11 side write lands");

        // R4 pair halves, R1 quad is pair mode on a 64-bit base
        run_op(4, 6, 2, rnd128(), "R4/R1 pair 4,6");
        // R5 zero pair base hides register 1
        run_op(0, 0, 2, rnd128(), "R5 zero pairs");
        check("R5 reg1 nonzero premise", OPW'(model[1] != 0), OPW'(1));
        // R2 reserved encodings
        run_op(3, 6, 2, rnd128(), "R2 odd rd");
        run_op(4, 5, 2, rnd128(), "R2 odd rs2");
        run_op(4, 6, 3, rnd128(), "R2 size 3");
        // R1 odd indices are fine in single mode
        run_op(3, 5, 1, rnd128(), "R1 single odd");
        // R7 pair write-back
        run_op(8, 2, 2, 128'h1111_2222_3333_4444_5555_6666_7777_8888, "R7 pair wb");
        peek(8, 64'h5555_6666_7777_8888, "R7 even gets low half");
        peek(9, 64'h1111_2222_3333_4444, "R7 odd gets high half");
        // R8 destination pair at 0 discards the result
        begin
            logic [XLEN-1:0] r1;
            r1 = model[1];
            run_op(0, 10, 2, rnd128(), "R8 discard");
            peek(1, r1, "R8 reg1 unchanged");
        end
        // R9 sign-extended word, full double
        run_op(10, 0, 0, 128'h0_0000_0000_8000_0001, "R9 word neg");
        peek(10, 64'hFFFF_FFFF_8000_0001, "R9 sign extend");
        run_op(11, 0, 0, 128'h0_0000_0000_7000_0002, "R9 word pos");
        peek(11, 64'h0000_0000_7000_0002, "R9 positive word");
        run_op(12, 0, 1, 128'hAAAA_0000_0000_0000_8123_4567_89AB_CDEF, "R9 double");
        peek(12, 64'h8123_4567_89AB_CDEF, "R9 double full");
        // R6 narrow word operand
        ext_write(14, 64'hF0F0_F0F0_8765_4321);
        run_op(14, 14, 0, rnd128(), "R6 narrow word");
        // R10 issue while busy is ignored, response while idle writes nothing
        begin
            logic [XLEN-1:0] r16;
            issue_valid = 1'b1; issue_rd = 5'd16; issue_rs2 = 5'd2; issue_size = 2'd1;
            @(posedge clk); @(negedge clk);
            issue_rd = 5'd3; issue_size = 2'd3;
            @(posedge clk); @(negedge clk);
            issue_valid = 1'b0;
            check("R10 busy issue no flag", OPW'(illegal), '0);
            check("R10 busy issue no req", OPW'(mem_req_valid), '0);
            check("R10 held busy", OPW'(busy), OPW'(1));
            mem_rsp_valid = 1'b1; mem_rsp_data = 128'h0_0000_0000_0000_0000_0000_1234;
            @(posedge clk); @(negedge clk);
            mem_rsp_data = 128'h0_0000_0000_0000_0000_0000_9999;
            @(posedge clk); @(negedge clk);
            mem_rsp_valid = 1'b0;
            model[16] = 64'h1234;
            r16 = model[16];
            peek(16, r16, "R10 idle rsp ignored");
        end

        // Constrained random traffic
        for (int n = 0; n < 400; n++) begin
            int rd, rs2, sz;
            rd  = $urandom % 32;
            rs2 = $urandom % 32;
            if (($urandom % 4) != 0) rd  = rd & ~1;
            if (($urandom % 4) != 0) rs2 = rs2 & ~1;
            sz = $urandom % 4;
            if (($urandom % 8) == 0) ext_write(1 + ($urandom % 31), {$urandom, $urandom});
            run_op(rd, rs2, sz, rnd128(), "random R3");
        end
        for (int i = 0; i < 32; i++) peek(i, model[i], "R9 final register state");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule